// File: doc/BRIEF.md
# Local Interrupt Source Channel

This block is one entry of a local interrupt table. It conditions a single raw interrupt source, such as an external pin, a timer tick or an error line, and turns it into a delivery request towards the core. Software programs the channel through a 32-bit configuration word. The word selects a vector number, a delivery class, the active level of the input, edge or level sensing, and a mask. The word can be rewritten at any time.

The raw input first passes through a synchronizer and is then corrected for polarity. Edge or level qualification follows. A qualified event raises one outstanding request. The request's class decides which request output is driven: fixed (which carries the vector), SMI, NMI or external pass-through. The core takes the request with a one-cycle `accept` strobe. For level-sensed sources, the end of service is signalled with a one-cycle `eoi` strobe. Two read-only status bits in the word report a pending send and remote acceptance. A table of such channels is formed by placing instances at a fixed 16-byte address stride.

Top module: `lvt_channel`

## Requirements
- R1: After reset the word reads 0x0001_0000 (mask set, all other fields zero) and no request output is active.
- R2: Bits 7:0 (vector), 10:8 (delivery class), 13 (polarity), 15 (trigger) and 16 (mask) are written by `cfg_we` and read back on `cfg_rdata` from the next cycle. Bit 12 reads the delivery status and bit 14 reads remote IRR; writes to those two bits are ignored. All other bits read 0.
- R3: The input passes through SYNC_STAGES flops. Polarity bit 13 = 0 makes high active and 1 makes low active.
- R4: With bit 15 = 0 (edge), each inactive-to-active change of the polarity-corrected input raises one request, which becomes visible SYNC_STAGES+1 clock edges after the input changes. An edge that arrives while a request is pending is dropped.
- R5: With bit 15 = 1 (level), an active input raises a request while remote IRR is 0. Accepting a request that was raised in level mode sets remote IRR. `eoi` clears it. If the input is still active, the request is raised again on the following edge.
- R6: While mask bit 16 is 1, no new request is raised. A request already pending stays pending until it is accepted.
- R7: Delivery status (bit 12) is 1 from the edge that raises a request until the edge that sees `accept`. An `accept` with nothing pending has no effect.
- R8: Class 000 drives `fixed_req`, with `fixed_vec` equal to the vector. Class 010 drives `smi_req`, class 100 drives `nmi_req` and class 111 drives `ext_req`. `fixed_vec` is 0 except for a fixed request. The other codes (001, 011, 101, 110) raise nothing.
- R9: The class, vector and trigger mode are captured when a request is raised. Rewriting the word while the request is pending leaves the request outputs unchanged.
- R10: When `accept` of a level request and `eoi` arrive in the same cycle, remote IRR ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word to write |
| cfg_rdata | output | 32 | Configuration word with status bits |
| src_in | input | 1 | Raw interrupt source |
| accept | input | 1 | Core takes the pending request |
| eoi | input | 1 | End of service for a level request |
| fixed_req | output | 1 | Fixed-class request |
| fixed_vec | output | 8 | Vector of the fixed request |
| smi_req | output | 1 | SMI-class request |
| nmi_req | output | 1 | NMI-class request |
| ext_req | output | 1 | External pass-through request |

## Verification
The bench attacks five cases:
- An edge arrives while a request is pending. A design that queued or re-armed on it would deliver a second interrupt after the accept.
- A level source is still active after service. A design that ignored remote IRR would raise a request again straight after the accept instead of waiting for `eoi`.
- `accept` and `eoi` arrive together. A design that gave `eoi` priority would lose the acceptance and re-raise the request at once.
- The word is rewritten while a request is pending, and the mask is set on a pending request. The first must not change the class or vector in flight, and the second must not cancel the request.
- All four classes and one reserved code are driven through the routing. A wrong decode would show up as the wrong output being driven, or as a request raised for the reserved code.

// File: rtl/lvt_pkg.sv
package lvt_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned VEC_W    = 8;
  localparam int unsigned MODE_W   = 3;
  localparam int unsigned VEC_LSB  = 0;
  localparam int unsigned MODE_LSB = 8;
  localparam int unsigned STAT_BIT = 12;
  localparam int unsigned POL_BIT  = 13;
  localparam int unsigned RIRR_BIT = 14;
  localparam int unsigned TRIG_BIT = 15;
  localparam int unsigned MASK_BIT = 16;

  localparam logic [MODE_W-1:0] DM_FIXED = 3'b000;
  localparam logic [MODE_W-1:0] DM_SMI   = 3'b010;
  localparam logic [MODE_W-1:0] DM_NMI   = 3'b100;
  localparam logic [MODE_W-1:0] DM_EXT   = 3'b111;

  typedef struct packed {
    logic              mask;
    logic              trig;   // 1 = level
    logic              pol;    // 1 = active low
    logic [MODE_W-1:0] mode;
    logic [VEC_W-1:0]  vec;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{mask: 1'b1, trig: 1'b0, pol: 1'b0,
                                 mode: '0, vec: '0};

  // True for the four delivery classes that produce a request
  function automatic logic mode_legal(logic [MODE_W-1:0] m);
    return (m == DM_FIXED) || (m == DM_SMI) || (m == DM_NMI) || (m == DM_EXT);
  endfunction

  // Assemble the software-visible word from fields and status
  function automatic logic [WORD_W-1:0] pack_word(cfg_t c, logic stat, logic rirr);
    logic [WORD_W-1:0] w;
    w = '0;
    w[VEC_LSB +: VEC_W]   = c.vec;
    w[MODE_LSB +: MODE_W] = c.mode;
    w[STAT_BIT]           = stat;
    w[POL_BIT]            = c.pol;
    w[RIRR_BIT]           = rirr;
    w[TRIG_BIT]           = c.trig;
    w[MASK_BIT]           = c.mask;
    return w;
  endfunction
endpackage

// File: rtl/lvt_cfg_reg.sv
module lvt_cfg_reg
  import lvt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [WORD_W-1:0] wdata,
  output cfg_t              cfg
);
  logic unused_wbits;
  assign unused_wbits = ^{wdata[WORD_W-1:MASK_BIT+1], wdata[RIRR_BIT],
                          wdata[STAT_BIT:MODE_LSB+MODE_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= CFG_RESET;
    end else if (we) begin
      cfg.vec  <= wdata[VEC_LSB +: VEC_W];
      cfg.mode <= wdata[MODE_LSB +: MODE_W];
      cfg.pol  <= wdata[POL_BIT];
      cfg.trig <= wdata[TRIG_BIT];
      cfg.mask <= wdata[MASK_BIT];
    end
  end

  // R2: a write lands in the fields on the following cycle
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (cfg.mask == $past(wdata[MASK_BIT])) && (cfg.vec == $past(wdata[VEC_LSB +: VEC_W])));
endmodule

// File: rtl/lvt_sync.sv
module lvt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic pol,
  output logic act,
  output logic rise
);
  logic [STAGES-1:0] sh;
  logic              act_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= raw;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], raw};
      end
    end
  endgenerate

  assign act  = sh[STAGES-1] ^ pol;
  assign rise = act & ~act_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_d <= 1'b0;
    else        act_d <= act;
  end

  // R4: a rise is never reported on two consecutive cycles
  p_single_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/lvt_deliver.sv
module lvt_deliver
  import lvt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  cfg_t             cfg,
  input  logic             act,
  input  logic             rise,
  input  logic             accept,
  input  logic             eoi,
  output logic             pend,
  output logic             rirr,
  output logic             fixed_req,
  output logic [VEC_W-1:0] fixed_vec,
  output logic             smi_req,
  output logic             nmi_req,
  output logic             ext_req
);
  logic              raise;
  logic              take;
  logic [MODE_W-1:0] req_mode_q;
  logic [VEC_W-1:0]  req_vec_q;
  logic              req_lvl_q;

  assign raise = !pend && !cfg.mask && mode_legal(cfg.mode) &&
                 (cfg.trig ? (act && !rirr) : rise);
  assign take  = pend && accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend       <= 1'b0;
      req_mode_q <= '0;
      req_vec_q  <= '0;
      req_lvl_q  <= 1'b0;
    end else if (take) begin
      pend <= 1'b0;
    end else if (raise) begin
      pend       <= 1'b1;
      req_mode_q <= cfg.mode;
      req_vec_q  <= cfg.vec;
      req_lvl_q  <= cfg.trig;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  rirr <= 1'b0;
    else if (take && req_lvl_q)  rirr <= 1'b1;
    else if (eoi)                rirr <= 1'b0;
  end

  assign fixed_req = pend && (req_mode_q == DM_FIXED);
  assign smi_req   = pend && (req_mode_q == DM_SMI);
  assign nmi_req   = pend && (req_mode_q == DM_NMI);
  assign ext_req   = pend && (req_mode_q == DM_EXT);
  assign fixed_vec = fixed_req ? req_vec_q : '0;

  // R8: at most one request output at a time
  p_onehot_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fixed_req, smi_req, nmi_req, ext_req}));
  // R7: accept retires the pending request
  p_accept_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && accept) |=> !pend);
  // R6: mask stops a new request
  p_mask_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && cfg.mask) |=> !pend);
  // R5: remote IRR only rises on an accepted request
  p_rirr_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rirr) |-> $past(pend && accept));
  // R5: level sensing waits for EOI while remote IRR is set
  p_level_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rirr && cfg.trig && !pend) |=> !pend);
  // R9: captured request stays put until accepted
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !accept) |=> pend && $stable(req_vec_q) && $stable(req_mode_q));
endmodule

// File: rtl/lvt_channel.sv
module lvt_channel #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        src_in,
  input  logic        accept,
  input  logic        eoi,
  output logic        fixed_req,
  output logic [7:0]  fixed_vec,
  output logic        smi_req,
  output logic        nmi_req,
  output logic        ext_req
);
  import lvt_pkg::*;

  cfg_t cfg;
  logic act, rise, pend, rirr;

  lvt_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg)
  );

  lvt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   (src_in),
    .pol   (cfg.pol),
    .act   (act),
    .rise  (rise)
  );

  lvt_deliver u_dlv (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg       (cfg),
    .act       (act),
    .rise      (rise),
    .accept    (accept),
    .eoi       (eoi),
    .pend      (pend),
    .rirr      (rirr),
    .fixed_req (fixed_req),
    .fixed_vec (fixed_vec),
    .smi_req   (smi_req),
    .nmi_req   (nmi_req),
    .ext_req   (ext_req)
  );

  assign cfg_rdata = pack_word(cfg, pend, rirr);

  // R7: status bit tracks the request outputs
  p_status_matches_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[STAT_BIT] == (fixed_req | smi_req | nmi_req | ext_req));
endmodule

// File: tb/lvt_channel_tb.sv
module lvt_channel_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        src_in = 1'b0, accept = 1'b0, eoi = 1'b0;
  logic        fixed_req, smi_req, nmi_req, ext_req;
  logic [7:0]  fixed_vec;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  lvt_channel #(.SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .src_in(src_in), .accept(accept), .eoi(eoi),
    .fixed_req(fixed_req), .fixed_vec(fixed_vec), .smi_req(smi_req),
    .nmi_req(nmi_req), .ext_req(ext_req)
  );

  // ---------------- reference model ----------------
  bit   hist[$];
  bit   m_actd, m_pend, m_rirr, m_lvl;
  int   m_vec, m_mode, m_rvec, m_rmode;
  bit   m_pol, m_trig, m_mask;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {};
      for (int i = 0; i < SYNC; i++) hist.push_back(1'b0);
      m_actd = 0; m_pend = 0; m_rirr = 0; m_lvl = 0;
      m_vec = 0; m_mode = 0; m_rvec = 0; m_rmode = 0;
      m_pol = 0; m_trig = 0; m_mask = 1;
    end else begin
      bit a, edge_seen, ok, go, took;
      a = hist[0] ^ m_pol;
      edge_seen = a && !m_actd;
      ok = (m_mode == 0) || (m_mode == 2) || (m_mode == 4) || (m_mode == 7);
      go = !m_pend && !m_mask && ok && (m_trig ? (a && !m_rirr) : edge_seen);
      took = m_pend && accept;
      if (took && m_lvl) m_rirr = 1;
      else if (eoi)      m_rirr = 0;
      if (took) m_pend = 0;
      else if (go) begin
        m_pend = 1; m_rmode = m_mode; m_rvec = m_vec; m_lvl = m_trig;
      end
      m_actd = a;
      hist.push_back(src_in);
      void'(hist.pop_front());
      if (cfg_we) begin
        m_vec  = int'(cfg_wdata[7:0]);
        m_mode = int'(cfg_wdata[10:8]);
        m_pol  = cfg_wdata[13];
        m_trig = cfg_wdata[15];
        m_mask = cfg_wdata[16];
      end
    end
  end

  function automatic logic [31:0] exp_word();
    logic [31:0] w;
    w = '0;
    w[7:0] = 8'(m_vec);
    w[10:8] = 3'(m_mode);
    w[12] = m_pend; w[13] = m_pol; w[14] = m_rirr;
    w[15] = m_trig; w[16] = m_mask;
    return w;
  endfunction

  task automatic check(string t, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", t, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check({tag, " word"}, cfg_rdata, exp_word());
      check({tag, " outputs"}, {28'h0, fixed_req, smi_req, nmi_req, ext_req},
            {28'h0, m_pend && m_rmode == 0, m_pend && m_rmode == 2,
             m_pend && m_rmode == 4, m_pend && m_rmode == 7});
      check({tag, " vector"}, {24'h0, fixed_vec},
            (m_pend && m_rmode == 0) ? m_rvec : 0);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr(logic [31:0] w);
    cfg_we = 1'b1; cfg_wdata = w; @(negedge clk); cfg_we = 1'b0;
  endtask
  task automatic pulse_acc();
    accept = 1'b1; @(negedge clk); accept = 1'b0;
  endtask
  task automatic pulse_eoi();
    eoi = 1'b1; @(negedge clk); eoi = 1'b0;
  endtask
  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check("R1 reset word", cfg_rdata, 32'h0001_0000);
    check("R1 reset outputs", {28'h0, fixed_req, smi_req, nmi_req, ext_req}, 32'h0);

    tag = "R2";
    wr(32'hFFFF_FFFF);
    check("R2 readback", cfg_rdata, 32'h0001_A7FF);
    wr(32'h0000_0045);

    tag = "R4";
    src_in = 1; idle(SYNC + 1);
    check("R4 edge request", {fixed_req, fixed_vec}, {1'b1, 8'h45});
    src_in = 0; idle(2); src_in = 1; idle(4);
    pulse_acc(); idle(5);
    check("R4 dropped edge", {31'h0, fixed_req}, 32'h0);
    src_in = 0; idle(3);

    tag = "R7";
    pulse_acc(); idle(2);
    check("R7 idle accept", cfg_rdata, 32'h0000_0045);

    tag = "R3";
    src_in = 1; idle(4);
    wr(32'h0000_2045); idle(3);
    src_in = 0; idle(SYNC + 1);
    check("R3 active low", {31'h0, fixed_req}, 32'h1);
    pulse_acc(); src_in = 1; idle(3);

    tag = "R8";
    for (int k = 0; k < 4; k++) begin
      logic [2:0] m;
      logic [3:0] e;
      m = (k == 0) ? 3'b010 : (k == 1) ? 3'b100 : (k == 2) ? 3'b111 : 3'b001;
      e = (k == 0) ? 4'b0100 : (k == 1) ? 4'b0010 : (k == 2) ? 4'b0001 : 4'b0000;
      wr(32'h0001_0000); src_in = 0; idle(4); pulse_acc(); idle(1);
      wr({21'h0, m, 8'h33});
      src_in = 1; idle(SYNC + 1);
      check("R8 routing", {20'h0, fixed_vec, fixed_req, smi_req, nmi_req, ext_req},
            {20'h0, 8'h00, e});
      pulse_acc(); idle(2);
    end

    tag = "R6";
    wr(32'h0001_0033); src_in = 0; idle(4);
    src_in = 1; idle(5);
    check("R6 masked", {31'h0, fixed_req}, 32'h0);
    src_in = 0; idle(4);
    wr(32'h0000_0033); src_in = 1; idle(4);
    wr(32'h0001_0033); idle(2);
    check("R6 pending kept", {31'h0, fixed_req}, 32'h1);
    pulse_acc(); idle(2);

    tag = "R9";
    wr(32'h0000_0045); src_in = 0; idle(4);
    src_in = 1; idle(4);
    wr(32'h0000_0499); idle(2);
    check("R9 captured", {fixed_req, nmi_req, fixed_vec}, {1'b1, 1'b0, 8'h45});
    pulse_acc(); idle(2);

    tag = "R5";
    src_in = 0; idle(4);
    wr(32'h0000_8077);
    src_in = 1; idle(4);
    pulse_acc(); idle(1);
    check("R5 remote irr set", {31'h0, cfg_rdata[14] & ~fixed_req}, 32'h1);
    idle(3);
    check("R5 wait for eoi", {31'h0, fixed_req}, 32'h0);
    pulse_eoi(); idle(1);
    check("R5 re-raise", {31'h0, fixed_req}, 32'h1);
    src_in = 0; pulse_acc(); idle(2); pulse_eoi(); idle(4);
    check("R5 quiet after release", {31'h0, fixed_req}, 32'h0);

    tag = "R10";
    src_in = 1; idle(4);
    accept = 1; eoi = 1; @(negedge clk); accept = 0; eoi = 0;
    idle(1);
    check("R10 accept wins", {31'h0, cfg_rdata[14]}, 32'h1);
    pulse_eoi(); src_in = 0; idle(4);

    finish_run();
  end
endmodule